// File: doc/BRIEF.md
# Clamped PWM Generator with Clock Divider

This block turns an unsigned duty command from a speed controller into one pulse-width-modulated output. A prescaler divides the fast system clock into a slower enable tick. A period counter of `CNT_W` bits advances once per tick and wraps, so one period spans `2**CNT_W` ticks. The output is high while the counter is below the held duty value. That duty value can be any integer from 0 up to `2**CNT_W`, which gives every step from fully off to fully on.

Commands larger than `2**CNT_W` saturate to that full-on value. A new command is taken only when the counter wraps, so a change never cuts or stretches the pulse that is in progress. A separate negative-trigger input from the controller forces the output low for as long as it is held. The motor it drives cannot be reversed, so 0% duty is the safe response. The output is registered and lags the counter by one system clock.

Top module: `pwm_gen`

## Requirements
- R1: While rst_ni is low, pwm_o is low. After rst_ni rises, the held duty is 0, so pwm_o stays low for the whole first period, whatever the command.
- R2: The counter advances once every CLK_DIV system clocks. Rising edges of pwm_o are therefore 2**CNT_W * CLK_DIV clocks apart.
- R3: For a command d in 0..2**CNT_W, pwm_o is high for d * CLK_DIV consecutive clocks in each period. A command of 0 keeps pwm_o low, and a command of 2**CNT_W keeps it high.
- R4: Any command greater than 2**CNT_W gives the same output as 2**CNT_W.
- R5: A command change takes effect only when the counter wraps. The pulse in progress keeps its old width, and the next period uses the new width.
- R6: When neg_trig_i is high, pwm_o is low on the following clock. When neg_trig_i falls, pwm_o resumes normal duty on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| duty_cmd_i | input | CMD_W | Unsigned duty command, saturated at 2**CNT_W |
| neg_trig_i | input | 1 | Negative trigger from the controller; forces the output low |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench builds the block with CLK_DIV=3, CNT_W=7 and CMD_W=8. With these values one period is 384 clocks, so whole-period duty windows, rise-to-rise spacing and mid-pulse command changes all fit in short runs. The divider above 1 also makes each counter step span several clocks, which exposes off-by-one errors in the prescaler. An 8-bit command reaches 129 and 255, so the saturation path is driven as well as the exact full-on value.

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned CLK_DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & (&cnt_q);
endmodule

// File: rtl/pwm_duty_hold.sv
module pwm_duty_hold #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned CMD_W = 8,
  localparam int unsigned DUTY_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int unsigned FULL = 2 ** CNT_W;
  logic [31:0]       cmd_u;
  logic [DUTY_W-1:0] sat_d, duty_q;

  assign cmd_u = 32'(cmd_i);
  assign sat_d = (cmd_u > FULL) ? DUTY_W'(FULL) : DUTY_W'(cmd_u);

  // only reload at period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (load_i) duty_q <= sat_d;
  end
  assign duty_o = duty_q;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int unsigned CLK_DIV = 12,
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned CMD_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] duty_cmd_i,
  input  logic             neg_trig_i,
  output logic             pwm_o
);
  localparam int unsigned DUTY_W = CNT_W + 1;

  logic              tick;
  logic              wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic [DUTY_W-1:0] duty_q;
  logic              pwm_q;

  pwm_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  pwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cnt_o(cnt_q), .wrap_o(wrap)
  );

  pwm_duty_hold #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_duty (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wrap), .cmd_i(duty_cmd_i), .duty_o(duty_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= ~neg_trig_i & ({1'b0, cnt_q} < duty_q);
  end
  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int unsigned CNT_W = 7,
  localparam int unsigned DUTY_W = CNT_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              neg_trig_i,
  input logic              pwm_o,
  input logic              tick,
  input logic              wrap,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DUTY_W-1:0] duty_q
);
  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(2 ** CNT_W);

  a_r1_low_in_reset: assert property (@(posedge clk_i) !rst_ni |-> !pwm_o);
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));
  a_r2_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q == '0 |=> !pwm_o);
  a_r3_full_duty_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == FULL && !neg_trig_i) |=> pwm_o);
  a_r4_duty_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q <= FULL);
  a_r5_duty_only_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(duty_q));
  a_r6_trigger_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_trig_i |=> !pwm_o);
endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .neg_trig_i(neg_trig_i), .pwm_o(pwm_o),
  .tick(tick), .wrap(wrap), .cnt_q(cnt_q), .duty_q(duty_q)
);

// File: tb/sim_pwm_gen.sv
module sim_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIV    = 3;
  localparam int CW     = 7;
  localparam int MW     = 8;
  localparam int PER    = (2 ** CW) * DIV;
  localparam int NV     = 9;
  // stimulus table: command, trigger, expected duty steps
  localparam logic [7:0] V_CMD [NV] = '{8'd0, 8'd1, 8'd64, 8'd127, 8'd128, 8'd129, 8'd255, 8'd90, 8'd200};
  localparam logic       V_NEG [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int         V_EXP [NV] = '{0, 1, 64, 127, 128, 128, 128, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MW-1:0] cmd = '0;
  logic neg = 1'b0;
  logic pwm;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_gen #(.CLK_DIV(DIV), .CNT_W(CW), .CMD_W(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .duty_cmd_i(cmd), .neg_trig_i(neg), .pwm_o(pwm)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_high(output int hi);
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (pwm) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi, w, gap;
    // R1: low during reset
    repeat (3) @(negedge clk);
    chk("R1 reset low", int'(pwm), 0);
    cmd = 8'd128;
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk("R1 first period low", int'(pwm), 0);
    repeat (180) @(negedge clk);
    chk("R1 first period low end", int'(pwm), 0);
    repeat (10) @(negedge clk);
    chk("R1 duty after first wrap", int'(pwm), 1);

    // table walk: R3, R4, R6
    for (int v = 0; v < NV; v++) begin
      cmd = V_CMD[v];
      neg = V_NEG[v];
      repeat (2 * PER) @(negedge clk);
      count_high(hi);
      chk($sformatf("R3/R4/R6 vec %0d cmd %0d", v, V_CMD[v]), hi, V_EXP[v] * DIV);
    end
    neg = 1'b0;

    // R2: rise-to-rise spacing
    cmd = 8'd64;
    repeat (2 * PER) @(negedge clk);
    wait_rise();
    pulse_width(w);
    gap = w;
    while (!pwm) begin
      gap++;
      @(negedge clk);
    end
    chk("R2 period length", gap, PER);

    // R5: increase mid-pulse
    cmd = 8'd40;
    repeat (2 * PER) @(negedge clk);
    wait_rise();
    repeat (3) @(negedge clk);
    cmd = 8'd100;
    pulse_width(w);
    chk("R5 current pulse kept (up)", w + 3, 40 * DIV);
    while (!pwm) @(negedge clk);
    pulse_width(w);
    chk("R5 next pulse new (up)", w, 100 * DIV);

    // R5: decrease mid-pulse
    while (!pwm) @(negedge clk);
    repeat (3) @(negedge clk);
    cmd = 8'd20;
    pulse_width(w);
    chk("R5 current pulse kept (down)", w + 3, 100 * DIV);
    while (!pwm) @(negedge clk);
    pulse_width(w);
    chk("R5 next pulse new (down)", w, 20 * DIV);

    // R6: immediate force and release at full duty
    cmd = 8'd128;
    repeat (2 * PER) @(negedge clk);
    chk("R6 high before trigger", int'(pwm), 1);
    neg = 1'b1;
    @(negedge clk);
    chk("R6 low one clock after trigger", int'(pwm), 0);
    repeat (5) @(negedge clk);
    chk("R6 held low", int'(pwm), 0);
    neg = 1'b0;
    @(negedge clk);
    chk("R6 resumes after release", int'(pwm), 1);

    // R1: asynchronous reset mid-pulse
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset drops output", int'(pwm), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 held duty cleared by reset", int'(pwm), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule